// File: doc/BRIEF.md
# Flash command sequence controller

This block is the control logic on the device side of a byte-wide flash memory with a 19-bit address space. It watches write bus cycles and decodes multi-step unlock sequences. These sequences start a byte program or a chip erase, enable a permanent write lock on a 16 KiB boot sector, and switch an identification read mode on and off. Program and erase run against an internal cycle-count timer. While an operation runs, reads return status bits instead of array data.

The storage is a small behavioural byte file of `2**IDX_W` bytes. Its upper half aliases the boot sector and its lower half aliases the main array. The entry index is `{addr_in_boot, addr[IDX_W-2:0]}`. A bus cycle is sampled on each rising clock edge: one cycle with the write qualifiers active is one write, and one cycle with the read qualifiers active is one read. Reads are combinational from state.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset every byte reads FFh, the lock is off and the identification mode is off. `bus_rdata` is 00h in any cycle that is not a read.
- R2: The write sequence 5555h/AAh, 2AAAh/55h, 5555h/A0h, then target/data starts a program. `PGM_CYC` cycles after the final write, the target byte reads as the old byte AND the new data.
- R3: The six writes 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, 5555h/10h start an erase. `ERASE_CYC` cycles after the last write, every byte reads FFh.
- R4: The same six writes ending in 40h set the lock. No command clears the lock. While it is set, a program into the boot sector is dropped, an erase leaves the boot sector untouched, and the main array stays writable.
- R5: After 5555h/AAh, 2AAAh/55h, 5555h/90h, reads return `ID_MAKER` at address 0, `ID_PART` at address 1, and the lock state on bit 0 of address 2 (1 = locked). Every other address reads 00h.
- R6: The identification mode ends on a write of F0h to any address, or on 5555h/AAh, 2AAAh/55h, 5555h/F0h. A write of F0h that is the data of a program does not end it. After the mode ends, reads return array data again.
- R7: A write whose address or data differs from the step the decoder expects returns the decoder to idle. The remaining steps of that sequence then have no effect.
- R8: During a busy operation, bits 5:0 of a read are 0. Bit 6 is 0 on the first read after the start and inverts on each later read. Bit 7 is the complement of the loaded bit 7 when the address read is the program target, and 0 otherwise, including during an erase.
- R9: Writes received while an operation is busy are ignored.
- R10: A write cycle with `bus_oe_n` low or `bus_sel_n` high has no effect.
- R11: With `TOP_BOOT`=0 the boot sector is 00000h–03FFFh, and with `TOP_BOOT`=1 it is 7C000h–7FFFFh. The address range of the other variant is part of the main array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus cycles sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n | input | 1 | Device select, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | 19 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, status, or identification byte |

## Verification
The main function is driven with directed program sequences: one where the AND with earlier contents is visible, one where the sequence is aborted at a wrong step, one where the writes are inhibited, and one issued while the block is busy. These tell real storage apart from sequences that were dropped or cut short. Status reads taken at the program target and at another address during program and erase tell data polling apart from the toggle bit. A random phase then draws addresses and data from a fixed seed across both halves of the array, before and after the lock, with occasional aborted prefixes. These draws separate the boot sector's protection from the main array's writability.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
    localparam int ADDR_W = 19;
    localparam int BOOT_W = 14;
    localparam logic [ADDR_W-1:0] UNLOCK_A = 19'h05555;
    localparam logic [ADDR_W-1:0] UNLOCK_B = 19'h02AAA;
    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] OP_PROGRAM = 8'hA0;
    localparam logic [7:0] OP_EXTEND  = 8'h80;
    localparam logic [7:0] OP_ID_ON   = 8'h90;
    localparam logic [7:0] OP_ID_OFF  = 8'hF0;
    localparam logic [7:0] OP_ERASE   = 8'h10;
    localparam logic [7:0] OP_LOCK    = 8'h40;

    typedef enum logic [2:0] {
        SEQ_IDLE, SEQ_K1, SEQ_K2, SEQ_DATA, SEQ_X3, SEQ_X4, SEQ_X5
    } seq_e;

    typedef enum logic [1:0] {OPK_NONE, OPK_PROG, OPK_ERASE} opk_e;

    typedef struct packed {
        logic lock;
        logic idm;
    } ctl_t;

    function automatic logic in_boot(input logic [ADDR_W-1:0] a, input logic top_variant);
        if (top_variant)
            return a[ADDR_W-1:BOOT_W] == {(ADDR_W-BOOT_W){1'b1}};
        return a[ADDR_W-1:BOOT_W] == '0;
    endfunction
endpackage

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              cmd_prog,
    output logic              cmd_erase,
    output logic              cmd_lock,
    output logic              cmd_id_on,
    output logic              cmd_id_off
);
    seq_e step_q, step_d;
    logic hit_a, hit_b;

    assign hit_a = (wr_addr == UNLOCK_A);
    assign hit_b = (wr_addr == UNLOCK_B);

    always_comb begin
        step_d     = step_q;
        cmd_prog   = 1'b0;
        cmd_erase  = 1'b0;
        cmd_lock   = 1'b0;
        cmd_id_on  = 1'b0;
        cmd_id_off = 1'b0;
        if (wr_stb) begin
            step_d = SEQ_IDLE;
            case (step_q)
                SEQ_IDLE: if (hit_a && wr_data == KEY_FIRST)  step_d = SEQ_K1;
                SEQ_K1:   if (hit_b && wr_data == KEY_SECOND) step_d = SEQ_K2;
                SEQ_K2: begin
                    if (hit_a) begin
                        if (wr_data == OP_PROGRAM)     step_d = SEQ_DATA;
                        else if (wr_data == OP_EXTEND) step_d = SEQ_X3;
                        else if (wr_data == OP_ID_ON)  cmd_id_on = 1'b1;
                    end
                end
                SEQ_DATA: cmd_prog = 1'b1;
                SEQ_X3:   if (hit_a && wr_data == KEY_FIRST)  step_d = SEQ_X4;
                SEQ_X4:   if (hit_b && wr_data == KEY_SECOND) step_d = SEQ_X5;
                SEQ_X5: begin
                    if (hit_a && wr_data == OP_ERASE)     cmd_erase = 1'b1;
                    else if (hit_a && wr_data == OP_LOCK) cmd_lock  = 1'b1;
                end
                default: step_d = SEQ_IDLE;
            endcase
            if (step_q != SEQ_DATA && wr_data == OP_ID_OFF)
                cmd_id_off = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= SEQ_IDLE;
        else        step_q <= step_d;
    end

    // R7: a decoded command is a single pulse of one kind
    assert_one_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_prog, cmd_erase, cmd_lock, cmd_id_on, cmd_id_off}));
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
    import flash_cmd_pkg::*;
#(
    parameter int PGM_CYC   = 20,
    parameter int ERASE_CYC = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_prog,
    input  logic              start_erase,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [7:0]        start_data,
    input  logic              rd_stb,
    output logic              busy,
    output opk_e              kind,
    output logic              done_prog,
    output logic              done_erase,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [7:0]        pend_data,
    output logic              tog
);
    localparam int CNT_MAX = (PGM_CYC > ERASE_CYC) ? PGM_CYC : ERASE_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        opk_e              kind;
        logic [CW-1:0]     cnt;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              tog;
    } tmr_t;

    tmr_t cur_q, cur_d;

    assign busy       = (cur_q.kind != OPK_NONE);
    assign kind       = cur_q.kind;
    assign done_prog  = (cur_q.kind == OPK_PROG)  && (cur_q.cnt == '0);
    assign done_erase = (cur_q.kind == OPK_ERASE) && (cur_q.cnt == '0);
    assign pend_addr  = cur_q.addr;
    assign pend_data  = cur_q.data;
    assign tog        = cur_q.tog;

    always_comb begin
        cur_d = cur_q;
        if (busy) begin
            if (cur_q.cnt == '0) cur_d.kind = OPK_NONE;
            else                 cur_d.cnt  = cur_q.cnt - 1'b1;
            if (rd_stb) cur_d.tog = ~cur_q.tog;
        end else if (start_prog) begin
            cur_d.kind = OPK_PROG;
            cur_d.cnt  = CW'(PGM_CYC - 1);
            cur_d.addr = start_addr;
            cur_d.data = start_data;
            cur_d.tog  = 1'b0;
        end else if (start_erase) begin
            cur_d.kind = OPK_ERASE;
            cur_d.cnt  = CW'(ERASE_CYC - 1);
            cur_d.tog  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{kind: OPK_NONE, cnt: '0, addr: '0, data: '0, tog: 1'b0};
        else        cur_q <= cur_d;
    end

    // R8: completion hands back to true data on the next cycle
    assert_done_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_prog || done_erase) |=> !busy);
    // R9: no operation is started while one is running
    assert_no_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(start_prog || start_erase));
endmodule

// File: rtl/flash_store.sv
module flash_store
    import flash_cmd_pkg::*;
#(
    parameter int IDX_W    = 6,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic              erase_en,
    input  logic              keep_boot,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte
);
    localparam int DEPTH = 1 << IDX_W;

    logic [7:0]       mem_q [DEPTH];
    logic [7:0]       mem_d [DEPTH];
    logic [IDX_W-1:0] p_idx, r_idx;

    assign p_idx   = {in_boot(prog_addr, TOP_BOOT), prog_addr[IDX_W-2:0]};
    assign r_idx   = {in_boot(rd_addr, TOP_BOOT), rd_addr[IDX_W-2:0]};
    assign rd_byte = mem_q[r_idx];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (erase_en && !(keep_boot && i >= DEPTH / 2))
                mem_d[i] = 8'hFF;
        end
        if (prog_en)
            mem_d[p_idx] = mem_q[p_idx] & prog_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    // R2: programming only clears bits
    assert_prog_and_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> mem_q[$past(p_idx)] == ($past(mem_q[p_idx]) & $past(prog_data)));
    // R4: a locked erase leaves the boot half alone
    assert_erase_keeps_boot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_en && keep_boot && !prog_en) |=> $stable(mem_q[DEPTH-1]));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int         PGM_CYC   = 20,
    parameter int         ERASE_CYC = 60,
    parameter int         IDX_W     = 6,
    parameter bit         TOP_BOOT  = 1'b0,
    parameter logic [7:0] ID_MAKER  = 8'hA5,
    parameter logic [7:0] ID_PART   = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    ctl_t ctl_q, ctl_d;
    logic wr_stb, rd_stb, busy, tog;
    logic cmd_prog, cmd_erase, cmd_lock, cmd_id_on, cmd_id_off;
    logic start_prog, done_prog, done_erase;
    opk_e kind;
    logic [ADDR_W-1:0] pend_addr;
    logic [7:0] pend_data, arr_byte, status;

    assign wr_stb     = !bus_sel_n && !bus_we_n && bus_oe_n && !busy;
    assign rd_stb     = !bus_sel_n && !bus_oe_n && bus_we_n;
    assign start_prog = cmd_prog && !(ctl_q.lock && in_boot(bus_addr, TOP_BOOT));

    flash_seq_decode u_dec (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(bus_addr), .wr_data(bus_wdata),
        .cmd_prog(cmd_prog), .cmd_erase(cmd_erase), .cmd_lock(cmd_lock),
        .cmd_id_on(cmd_id_on), .cmd_id_off(cmd_id_off)
    );

    flash_op_timer #(.PGM_CYC(PGM_CYC), .ERASE_CYC(ERASE_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(cmd_erase),
        .start_addr(bus_addr), .start_data(bus_wdata), .rd_stb(rd_stb),
        .busy(busy), .kind(kind), .done_prog(done_prog), .done_erase(done_erase),
        .pend_addr(pend_addr), .pend_data(pend_data), .tog(tog)
    );

    flash_store #(.IDX_W(IDX_W), .TOP_BOOT(TOP_BOOT)) u_mem (
        .clk(clk), .rst_n(rst_n), .prog_en(done_prog), .prog_addr(pend_addr),
        .prog_data(pend_data), .erase_en(done_erase), .keep_boot(ctl_q.lock),
        .rd_addr(bus_addr), .rd_byte(arr_byte)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (cmd_lock)   ctl_d.lock = 1'b1;
        if (cmd_id_on)  ctl_d.idm  = 1'b1;
        if (cmd_id_off) ctl_d.idm  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{lock: 1'b0, idm: 1'b0};
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        status = 8'h00;
        status[6] = tog;
        if (kind == OPK_PROG && bus_addr == pend_addr)
            status[7] = ~pend_data[7];
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (rd_stb) begin
            if (busy) bus_rdata = status;
            else if (ctl_q.idm) begin
                case (bus_addr)
                    19'h00000: bus_rdata = ID_MAKER;
                    19'h00001: bus_rdata = ID_PART;
                    19'h00002: bus_rdata = {7'b0, ctl_q.lock};
                    default:   bus_rdata = 8'h00;
                endcase
            end else bus_rdata = arr_byte;
        end
    end

    // R4: the lock never drops once set
    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.lock |=> ctl_q.lock);
    // R10: inhibited write cycles reach no command
    assert_inhibit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe_n || bus_sel_n) |->
        !(cmd_prog || cmd_erase || cmd_lock || cmd_id_on || cmd_id_off));
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
    localparam int PGM = 20;
    localparam int ERS = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel_n = 1'b1, bus_oe_n = 1'b1, bus_we_n = 1'b1;
    logic [18:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [7:0] m [64];
    bit mlock = 0;

    always #4 clk = ~clk;

    flash_cmd_ctrl #(.PGM_CYC(PGM), .ERASE_CYC(ERS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_oe_n(bus_oe_n),
        .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic bit inb(input logic [18:0] a);
        return a[18:14] == 5'h00;
    endfunction
    function automatic int midx(input logic [18:0] a);
        return {26'd0, inb(a), a[4:0]};
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    task automatic wrx(input logic [18:0] a, input logic [7:0] d, input logic sel, input logic oe);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_sel_n = sel; bus_oe_n = oe; bus_we_n = 1'b0;
        @(negedge clk);
        bus_we_n = 1'b1; bus_sel_n = 1'b1; bus_oe_n = 1'b1;
    endtask
    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        wrx(a, d, 1'b0, 1'b1);
    endtask
    task automatic rd(input logic [18:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_sel_n = 1'b0; bus_oe_n = 1'b0; bus_we_n = 1'b1;
        #2 v = bus_rdata;
        @(negedge clk);
        bus_sel_n = 1'b1; bus_oe_n = 1'b1;
    endtask
    task automatic rdchk(input string req, input logic [18:0] a);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, m[midx(a)]);
    endtask
    task automatic prog(input logic [18:0] a, input logic [7:0] d, input bit apply);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0); wr(a, d);
        if (apply && !(mlock && inb(a))) m[midx(a)] = m[midx(a)] & d;
    endtask
    task automatic six(input logic [7:0] last);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h80);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, last);
    endtask
    task automatic model_erase();
        for (int i = 0; i < 64; i++) if (!(mlock && i >= 32)) m[i] = 8'hFF;
    endtask
    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [18:0] a;
        logic [7:0] d;
        for (int i = 0; i < 64; i++) m[i] = 8'hFF;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rdchk("R1 erased after reset", 19'h40013);
        rdchk("R1 boot erased after reset", 19'h00005);
        @(negedge clk); bus_addr = 19'h40013; bus_sel_n = 1'b0; bus_oe_n = 1'b1;
        #2 chk("R1 no read gives 00", bus_rdata, 8'h00);
        bus_sel_n = 1'b1;

        // R2: program, then AND with old contents; R8 polling on the way
        prog(19'h40013, 8'h5A, 1); waitn(PGM + 3);
        rdchk("R2 program stores", 19'h40013);
        prog(19'h40013, 8'h0F, 1);
        rd(19'h40013, v); chk("R8 poll first read", v, 8'h80);
        rd(19'h40013, v); chk("R8 poll toggled", v, 8'hC0);
        rd(19'h40001, v); chk("R8 other addr toggle", v, 8'h00);
        rd(19'h40001, v); chk("R8 other addr toggle again", v, 8'h40);
        waitn(PGM + 3);
        rdchk("R2 AND of old and new", 19'h40013);
        chk("R2 AND value", m[midx(19'h40013)], 8'h0A);

        // R9: a second full program while busy is ignored
        prog(19'h40002, 8'h11, 1);
        prog(19'h40003, 8'h22, 0);
        waitn(PGM + 3);
        rdchk("R9 first program kept", 19'h40002);
        rdchk("R9 busy program dropped", 19'h40003);

        // R7: sequences broken at a wrong step
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA1); wr(19'h40004, 8'h00);
        waitn(PGM + 3);
        rdchk("R7 bad opcode aborts", 19'h40004);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h54); wr(19'h05555, 8'hA0); wr(19'h40004, 8'h00);
        waitn(PGM + 3);
        rdchk("R7 bad key aborts", 19'h40004);

        // R10: inhibited writes
        wrx(19'h05555, 8'hAA, 1'b0, 1'b0); wrx(19'h02AAA, 8'h55, 1'b0, 1'b0);
        wrx(19'h05555, 8'hA0, 1'b0, 1'b0); wrx(19'h40005, 8'h00, 1'b0, 1'b0);
        waitn(PGM + 3);
        rdchk("R10 output enable low inhibits", 19'h40005);
        wrx(19'h05555, 8'hAA, 1'b1, 1'b1); wrx(19'h02AAA, 8'h55, 1'b1, 1'b1);
        wrx(19'h05555, 8'hA0, 1'b1, 1'b1); wrx(19'h40005, 8'h00, 1'b1, 1'b1);
        waitn(PGM + 3);
        rdchk("R10 deselect inhibits", 19'h40005);

        // R5 / R6: identification mode
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h90);
        rd(19'h00000, v); chk("R5 maker id", v, 8'hA5);
        rd(19'h00001, v); chk("R5 part id", v, 8'h3C);
        rd(19'h00002, v); chk("R5 unlocked state", v, 8'h00);
        rd(19'h40013, v); chk("R5 other addr", v, 8'h00);
        wr(19'h12345, 8'hF0);
        rdchk("R6 single-write exit", 19'h40013);
        rdchk("R6 array at addr 2", 19'h00002);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h90);
        rd(19'h00001, v); chk("R5 re-entry", v, 8'h3C);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hF0);
        rdchk("R6 three-write exit", 19'h00001);

        // R11: boot sector writable before lock
        prog(19'h00005, 8'h33, 1); waitn(PGM + 3);
        rdchk("R11 boot writable unlocked", 19'h00005);

        // R3: erase with R8 status
        six(8'h10);
        rd(19'h40013, v); chk("R8 erase first read", v, 8'h00);
        rd(19'h40013, v); chk("R8 erase toggled", v, 8'h40);
        waitn(ERS + 3); model_erase();
        rdchk("R3 erase main", 19'h40013);
        rdchk("R3 erase boot", 19'h00005);
        rdchk("R3 erase other", 19'h40002);

        // R4: lock
        prog(19'h00005, 8'h77, 1); waitn(PGM + 3);
        six(8'h40); mlock = 1;
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h90);
        rd(19'h00002, v); chk("R4 lock reported", v, 8'h01);
        wr(19'h00000, 8'hF0);
        prog(19'h00006, 8'h12, 1); waitn(PGM + 3);
        rdchk("R4 boot program ignored", 19'h00006);
        prog(19'h7C010, 8'h3C, 1); waitn(PGM + 3);
        rdchk("R11 upper range is main when bottom boot", 19'h7C010);
        six(8'h10); waitn(ERS + 3); model_erase();
        rdchk("R4 boot kept by erase", 19'h00005);
        rdchk("R4 main erased", 19'h7C010);

        // R2 / R4 / R7: random programs
        for (int k = 0; k < 40; k++) begin
            a = 19'($urandom);
            d = 8'($urandom);
            if (a == 19'h05555 || a == 19'h02AAA) a = a ^ 19'h00100;
            if (k % 8 == 0) begin
                if (d == 8'hF0) d = 8'h0F;
                wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h54); wr(a, d);
                waitn(PGM + 3);
                rdchk("R7 random abort", a);
            end else begin
                prog(a, d, 1); waitn(PGM + 3);
                rdchk(inb(a) ? "R4 random boot" : "R2 random main", a);
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule